// File: doc/BRIEF.md
# Bank Configuration Controller with Preset Registers

This block sits beside an 8-bit CPU with a 16-bit address bus and decides, for each access, what answers it. The answer is one of RAM (with a 2-bit physical bank number), one of three ROM sources, the I/O area, or the controller's own registers. The decision comes from an active configuration byte. Its two upper bits choose one of four 64 KB RAM banks. Its lower six bits decide whether the I/O page and the ROM areas are visible.

There are two register windows. The main window lies in the I/O page, so it only answers while I/O is visible. It holds the active configuration, the preset registers and a common-area control register. The quick window is a few bytes at the start of the top page, and it answers in every configuration. A write to its first byte sets the configuration directly. A write to any later byte copies the matching preset into the configuration, whatever data is written. A single store can therefore switch between prepared memory maps even when the I/O page is hidden.

A common area of RAM can be placed at the bottom, at the top, or at both ends of the address space, in one of four sizes. RAM accesses that fall inside it always use bank 0.

Top module: `bank_ctrl`

## Requirements
- R1: After reset the configuration, all presets and the common control are zero. RAM accesses use bank 0, addresses 0x4000-0x7FFF and 0x8000-0xBFFF select ROM source 0, 0xD000-0xDFFF selects I/O, and the rest of 0xC000-0xFFFF selects ROM source 0.
- R2: Outside the common area, every RAM access drives ram_bank_o with configuration bits [7:6]. When ram_cs_o is low, ram_bank_o is 0.
- R3: Configuration bit 0 set hides I/O, so 0xD000-0xDFFF falls through to the top-area choice. Bit 1 set gives RAM at 0x4000-0x7FFF, and clear gives ROM source 0. Bits [3:2] choose for 0x8000-0xBFFF, and bits [5:4] choose for 0xC000-0xFFFF: code 0, 1 or 2 selects ROM source 0, 1 or 2, and code 3 selects RAM. 0x0000-0x3FFF is always RAM.
- R4: A write to QS_PAGE:01+k (k below N_PRESET) copies preset k into the configuration and ignores the written data. A write to QS_PAGE:00 loads the written byte into the configuration.
- R5: The quick window QS_PAGE:00 to QS_PAGE:N_PRESET is a register hit in every configuration.
- R6: Top-page addresses above the quick window are decoded as ordinary memory for 0xC000-0xFFFF.
- R7: Main window at REG_PAGE: offset 0 is the configuration, 1+k is preset k, and N_PRESET+1 is the common control. It is decoded only while I/O is visible. With I/O hidden, an access there does not hit and leaves every register unchanged.
- R8: Common control: bits [1:0] set the size (0: 1 KB, 1: 4 KB, 2: 8 KB, 3: 16 KB), bit 2 enables the bottom area and bit 3 enables the top area. A RAM access inside an enabled area uses bank 0. Upper bits read as zero.
- R9: A register read returns the last value written, or the value last copied in by a preset load. No register changes without a write access.
- R10: At most one of reg_hit_o, ram_cs_o, rom_cs_o and io_cs_o is high. With acc_i low, none of them is high and writes have no effect. rdata_o is 0 when there is no register hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | CPU access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Register read data, 0 when no register hit |
| reg_hit_o | output | 1 | Access hits a controller register |
| ram_cs_o | output | 1 | RAM selected |
| ram_bank_o | output | 2 | Physical RAM bank for a RAM access |
| rom_cs_o | output | 1 | ROM selected |
| rom_sel_o | output | 2 | ROM source 0..2 |
| io_cs_o | output | 1 | I/O area selected, register window excluded |

## Verification
The bench builds the block with its defaults: four presets, the main window at page 0xD5 and the quick window at page 0xFF. These values put every preset and the common control within reach of the random address mix. Random configurations often hide I/O or map the top area to RAM. That lets the bench confirm that the quick window still answers and that the main window goes silent in exactly those states. Random common-control values cover all four sizes at both ends, so accesses at the edges of the common area compare bank 0 with the configured bank.

// File: rtl/bank_pkg.sv
package bank_pkg;
  typedef struct packed {
    logic [1:0] bank;
    logic [1:0] hi_sel;
    logic [1:0] mid_sel;
    logic       lo_ram;
    logic       io_off;
  } cfg_t;

  typedef struct packed {
    logic       top_en;
    logic       bot_en;
    logic [1:0] size;
  } com_t;

  localparam logic [1:0] SEL_RAM = 2'd3;

  function automatic logic [16:0] com_span(logic [1:0] size);
    case (size)
      2'd0:    return 17'h00400;
      2'd1:    return 17'h01000;
      2'd2:    return 17'h02000;
      default: return 17'h04000;
    endcase
  endfunction
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_pkg::*;
#(
  parameter logic [7:0] REG_PAGE = 8'hD5,
  parameter logic [7:0] QS_PAGE  = 8'hFF,
  parameter int         N_PRESET = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output cfg_t        cfg_o,
  output com_t        com_o,
  output logic        hit_o,
  output logic [7:0]  rdata_o
);
  localparam logic [7:0] LAST_PRE = 8'(N_PRESET);
  localparam logic [7:0] COM_OFF  = 8'(N_PRESET + 1);

  cfg_t       cfg_q;
  com_t       com_q;
  logic [7:0] pre_q [N_PRESET];

  logic [7:0] off;
  logic       wr, main_pg, qs_pg, main_cfg, qs_cfg, main_com;
  logic [N_PRESET-1:0] main_pre, qs_pre;

  assign off      = addr_i[7:0];
  assign wr       = acc_i & we_i;
  assign main_pg  = (addr_i[15:8] == REG_PAGE) & ~cfg_q.io_off;
  assign qs_pg    = (addr_i[15:8] == QS_PAGE);
  assign main_cfg = main_pg & (off == 8'd0);
  assign qs_cfg   = qs_pg & (off == 8'd0);
  assign main_com = main_pg & (off == COM_OFF);
  assign hit_o    = acc_i & ((main_pg & (off <= COM_OFF)) | (qs_pg & (off <= LAST_PRE)));

  for (genvar k = 0; k < N_PRESET; k++) begin : g_pre
    assign main_pre[k] = main_pg & (off == 8'(k + 1));
    assign qs_pre[k]   = qs_pg & (off == 8'(k + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pre_q[k] <= '0;
      else if (wr && main_pre[k]) pre_q[k] <= wdata_i;
    end

    AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && qs_pre[k]) |=> (cfg_q == $past(pre_q[k]))); // R4
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      com_q <= '0;
    end else if (wr) begin
      if (qs_cfg || main_cfg) cfg_q <= cfg_t'(wdata_i);
      for (int k = 0; k < N_PRESET; k++)
        if (qs_pre[k]) cfg_q <= cfg_t'(pre_q[k]);
      if (main_com) com_q <= com_t'(wdata_i[3:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_o) begin
      if (main_cfg || qs_cfg) rdata_o = cfg_q;
      for (int k = 0; k < N_PRESET; k++)
        if (main_pre[k] || qs_pre[k]) rdata_o = pre_q[k];
      if (main_com) rdata_o = {4'b0, com_q};
    end
  end

  assign cfg_o = cfg_q;
  assign com_o = com_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(cfg_q)); // R9
  AST_COM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(com_q)); // R9
endmodule

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
(
  input  logic [15:0] addr_i,
  input  cfg_t        cfg_i,
  input  com_t        com_i,
  output logic        ram_o,
  output logic [1:0]  bank_o,
  output logic        rom_o,
  output logic [1:0]  rom_sel_o,
  output logic        io_o
);
  logic [16:0] span, a17;
  logic        in_com;

  assign a17    = {1'b0, addr_i};
  assign span   = com_span(com_i.size);
  assign in_com = (com_i.bot_en & (a17 < span)) |
                  (com_i.top_en & (a17 >= (17'h10000 - span)));
  assign bank_o = in_com ? 2'd0 : cfg_i.bank;

  always_comb begin
    ram_o     = 1'b0;
    rom_o     = 1'b0;
    rom_sel_o = 2'd0;
    io_o      = 1'b0;
    case (addr_i[15:14])
      2'd0: ram_o = 1'b1;
      2'd1: begin
        ram_o = cfg_i.lo_ram;
        rom_o = ~cfg_i.lo_ram;
      end
      2'd2: begin
        ram_o     = (cfg_i.mid_sel == SEL_RAM);
        rom_o     = ~ram_o;
        rom_sel_o = ram_o ? 2'd0 : cfg_i.mid_sel;
      end
      default: begin
        if (!cfg_i.io_off && addr_i[13:12] == 2'b01) io_o = 1'b1;
        else begin
          ram_o     = (cfg_i.hi_sel == SEL_RAM);
          rom_o     = ~ram_o;
          rom_sel_o = ram_o ? 2'd0 : cfg_i.hi_sel;
        end
      end
    endcase
  end
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
#(
  parameter logic [7:0] REG_PAGE = 8'hD5,
  parameter logic [7:0] QS_PAGE  = 8'hFF,
  parameter int         N_PRESET = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        reg_hit_o,
  output logic        ram_cs_o,
  output logic [1:0]  ram_bank_o,
  output logic        rom_cs_o,
  output logic [1:0]  rom_sel_o,
  output logic        io_cs_o
);
  cfg_t       cfg;
  com_t       com;
  logic       hit, ram, rom, io;
  logic [1:0] bank, sel;

  bank_regs #(.REG_PAGE(REG_PAGE), .QS_PAGE(QS_PAGE), .N_PRESET(N_PRESET)) u_regs (
    .clk_i, .rst_ni, .acc_i, .we_i, .addr_i, .wdata_i,
    .cfg_o(cfg), .com_o(com), .hit_o(hit), .rdata_o(rdata_o)
  );

  bank_map u_map (
    .addr_i, .cfg_i(cfg), .com_i(com),
    .ram_o(ram), .bank_o(bank), .rom_o(rom), .rom_sel_o(sel), .io_o(io)
  );

  // register hit wins over memory decode
  assign reg_hit_o  = hit;
  assign ram_cs_o   = acc_i & ~hit & ram;
  assign rom_cs_o   = acc_i & ~hit & rom;
  assign io_cs_o    = acc_i & ~hit & io;
  assign ram_bank_o = ram_cs_o ? bank : 2'd0;
  assign rom_sel_o  = rom_cs_o ? sel : 2'd0;

  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_hit_o, ram_cs_o, rom_cs_o, io_cs_o})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |-> !(reg_hit_o || ram_cs_o || rom_cs_o || io_cs_o)); // R10
  AST_IO_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.io_off |-> !io_cs_o); // R3
  AST_COMMON_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_cs_o && com.bot_en && addr_i < 16'h0400) |-> (ram_bank_o == 2'd0)); // R8
  AST_QS_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && addr_i == {QS_PAGE, 8'h00}) |-> (reg_hit_o && rdata_o == cfg)); // R5
endmodule

// File: tb/sim_bank_ctrl.sv
module sim_bank_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        reg_hit_o, ram_cs_o, rom_cs_o, io_cs_o;
  logic [1:0]  ram_bank_o, rom_sel_o;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] m_cfg;
  logic [7:0] m_pre [4];
  logic [3:0] m_com;

  always #4 clk_i = ~clk_i;

  bank_ctrl u0 (.*);

  function automatic logic [16:0] span_of(logic [1:0] s);
    case (s)
      2'd0: return 17'h00400;
      2'd1: return 17'h01000;
      2'd2: return 17'h02000;
      default: return 17'h04000;
    endcase
  endfunction

  function automatic logic in_common(logic [15:0] a);
    logic [16:0] sp;
    sp = span_of(m_com[1:0]);
    return (m_com[2] && {1'b0, a} < sp) || (m_com[3] && {1'b0, a} >= 17'h10000 - sp);
  endfunction

  // packing {hit, rdata[7:0], ram, bank[1:0], rom, sel[1:0], io}
  function automatic logic [15:0] expect_of(logic [15:0] a);
    logic hit, ram, rom, io;
    logic [7:0] rd;
    logic [1:0] bk, sl, code;
    hit = 0; rd = 0; ram = 0; rom = 0; io = 0; bk = 0; sl = 0;
    if (a[15:8] == 8'hFF && a[7:0] <= 8'd4) begin
      hit = 1;
      rd = (a[7:0] == 0) ? m_cfg : m_pre[a[2:0] - 3'd1];
    end else if (a[15:8] == 8'hD5 && !m_cfg[0] && a[7:0] <= 8'd5) begin
      hit = 1;
      if (a[7:0] == 0) rd = m_cfg;
      else if (a[7:0] == 5) rd = {4'b0, m_com};
      else rd = m_pre[a[2:0] - 3'd1];
    end else begin
      if (a < 16'h4000) ram = 1;
      else if (a < 16'h8000) begin ram = m_cfg[1]; rom = !m_cfg[1]; end
      else if (a >= 16'hD000 && a < 16'hE000 && !m_cfg[0]) io = 1;
      else begin
        code = (a < 16'hC000) ? m_cfg[3:2] : m_cfg[5:4];
        if (code == 2'd3) ram = 1;
        else begin rom = 1; sl = code; end
      end
      if (ram) bk = in_common(a) ? 2'd0 : m_cfg[7:6];
    end
    return {hit, rd, ram, bk, rom, sl, io};
  endfunction

  function automatic string tag_of(logic [15:0] a);
    if (a[15:8] == 8'hFF && a[7:0] <= 8'd4) return "R5";
    if (a[15:8] == 8'hFF) return "R6";
    if (a[15:8] == 8'hD5 && a[7:0] <= 8'd5) return "R7";
    if (in_common(a)) return "R8";
    if (a < 16'h4000) return "R2";
    return "R3";
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    logic [7:0] nc;
    nc = m_cfg;
    if (a[15:8] == 8'hFF && a[7:0] == 0) nc = d;
    else if (a[15:8] == 8'hFF && a[7:0] >= 1 && a[7:0] <= 4) nc = m_pre[a[2:0] - 3'd1];
    else if (a[15:8] == 8'hD5 && !m_cfg[0]) begin
      if (a[7:0] == 0) nc = d;
      else if (a[7:0] >= 1 && a[7:0] <= 4) m_pre[a[2:0] - 3'd1] = d;
      else if (a[7:0] == 5) m_com = d[3:0];
    end
    m_cfg = nc;
  endtask

  task automatic access(logic w, logic [15:0] a, logic [7:0] d, string tag);
    @(negedge clk_i);
    acc_i = 1; we_i = w; addr_i = a; wdata_i = d;
    #2;
    check((tag == "") ? tag_of(a) : tag,
          {reg_hit_o, rdata_o, ram_cs_o, ram_bank_o, rom_cs_o, rom_sel_o, io_cs_o},
          expect_of(a));
    @(posedge clk_i);
    #1;
    if (w) model_write(a, d);
    acc_i = 0; we_i = 0;
  endtask

  function automatic logic [15:0] rand_addr();
    case ($urandom % 6)
      0: return {8'hFF, 5'd0, 3'($urandom % 5)};
      1: return {8'hD5, 5'd0, 3'($urandom % 6)};
      2: return {8'hFF, 8'($urandom)};
      3: return 16'($urandom % 16'h0800) + (($urandom % 2) ? 16'hF800 : 16'h0000);
      4: return {4'hD, 12'($urandom)};
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cfg = 0; m_com = 0;
    for (int i = 0; i < 4; i++) m_pre[i] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1: reset map
    access(0, 16'hD500, 0, "R1");
    access(0, 16'h4000, 0, "R1");
    access(0, 16'h9000, 0, "R1");
    access(0, 16'hD000, 0, "R1");
    access(0, 16'hE000, 0, "R1");
    access(0, 16'h0100, 0, "R1");
    // R9: preset and common write/read back
    for (int k = 0; k < 4; k++) access(1, 16'hD501 + 16'(k), 8'h3C + 8'(k * 64), "R9");
    access(1, 16'hD505, 8'hFE, "R9");
    for (int k = 0; k < 6; k++) access(0, 16'hD500 + 16'(k), 0, "R9");
    // R4: preset copy ignores data; direct load
    access(1, 16'hFF02, 8'h00, "R4");
    access(0, 16'hFF00, 0, "R4");
    access(1, 16'hFF00, 8'hF1, "R4");
    access(0, 16'hFF00, 0, "R4");
    // R7: I/O hidden, main window silent, preset untouched
    access(1, 16'hD501, 8'h55, "R7");
    access(0, 16'hFF01, 0, "R7");
    access(0, 16'hD500, 0, "R7");
    // R5: quick window in hidden-I/O, top-RAM configuration
    access(1, 16'hFF04, 8'h00, "R5");
    access(0, 16'hFF03, 0, "R5");
    // R6: top page shows through
    access(0, 16'hFF05, 0, "R6");
    access(0, 16'hFFFC, 0, "R6");
    // R10: idle write has no effect
    @(negedge clk_i);
    acc_i = 0; we_i = 1; addr_i = 16'hFF00; wdata_i = 8'h01;
    #2 check("R10", {reg_hit_o, ram_cs_o, rom_cs_o, io_cs_o, rdata_o}, 12'h000);
    @(posedge clk_i); #1 we_i = 0;
    access(0, 16'hFF00, 0, "R10");
    // R8: both common areas at 16 KB with bank 3 and RAM everywhere
    access(1, 16'hFF00, 8'hF2, "R8");
    access(1, 16'hD505, 8'h0F, "R8");
    access(1, 16'hFF00, 8'hFE, "R8");
    access(0, 16'h3FFF, 0, "R8");
    access(0, 16'h4000, 0, "R8");
    access(0, 16'hC000, 0, "R8");
    access(0, 16'hBFFF, 0, "R8");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a = rand_addr();
      access(($urandom % 3) == 0, a, 8'($urandom), "");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule